// File: doc/BRIEF.md
# Compressed Instruction Decoder

This block sits in the decode stage of a small pipelined core that runs 16-bit RISC-V compressed instructions natively. Every cycle it takes one instruction half-word and turns it into a one-hot set of operation flags, plus two register-file port addresses: a write/primary port and a read-only secondary port. It also produces a write-enable qualifier. A half-word whose two low bits are both set begins a full-width 32-bit instruction. Such a word raises no compressed flag. It raises a separate flag that steers execution to a microcode trap path, and it points the write port at the return-address register.

Each operation is recognised by masking the funct and opcode bits of the word and comparing the result with a fixed pattern. A few qualifiers on register fields split encodings that share a pattern. Port addresses are built as an OR of candidate values, each one gated by a replicated decode strobe. All outputs are registered, so they appear one clock after the word is presented.

Top module: `rvc_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, every output is cleared at that edge: all flags, `isWide` and `wrEn` are 0, and both addresses are 0.
- R2: A word with bits [1:0] = 2'b11 sets `isWide` and no bit of `opFlags`. It sets `wrAddr` to 1 (ra). The output appears one clock after the word is presented.
- R3: The word is a load-word when bits [15:13] = 010 and bits [1:0] = 00. Its flag is `opFlags[1]`, and `wrAddr` is 8 + bits [4:2].
- R4: A register add has bits [15:12] = 1001, bits [1:0] = 10 and bits [6:2] non-zero. It raises `opFlags[25]`, with `wrAddr` = bits [11:7] and `rdAddr` = bits [6:2]. For example, 0x9196 gives wrAddr 3 and rdAddr 5.
- R5: With bits [15:12] = 1001, bits [1:0] = 10 and bits [6:2] = 0, two cases are distinguished. If bits [11:7] are non-zero, the word is a register jump-and-link, `opFlags[24]`, and `wrAddr` is 1. If the word is exactly 0x9002, it is a breakpoint, `opFlags[23]`, and `wrAddr` is 0. In neither case is the add flag raised. The immediate jump-and-link (bits [15:13] = 001, [1:0] = 01, `opFlags[4]`) also writes `wrAddr` 1.
- R6: `rdAddr` is 2 (sp) for the stack-relative add (`opFlags[0]`, bits [15:13] = 000 and [1:0] = 00 with bits [12:5] non-zero), the stack load (`opFlags[19]`) and the stack store (`opFlags[20]`).
- R7: `wrEn` is 1 exactly when the decoded operation writes a register, the resulting `wrAddr` is non-zero, and both `stallIn` and `bubbleIn` were low when the word was sampled.
- R8: At most one of `opFlags` and `isWide` is high in any cycle. Reserved encodings raise nothing: 0x0000, and bits [15:13] = 100, [12] = 1, [11:10] = 11, [1:0] = 01.
- R9: The `opFlags` bit order, from bit 0 to bit 25, is: stack-relative add, load, store, add-immediate, jump-and-link immediate, load-immediate, stack-pointer adjust, load-upper, shift-right-logical, shift-right-arithmetic, and-immediate, sub, xor, or, and, jump, branch-if-zero, branch-if-non-zero, shift-left, stack load, stack store, register jump, move, breakpoint, register jump-and-link, add.
- R10: The register-register group sub/xor/or/and (bits [15:10] = 100011, [1:0] = 01, selected by bits [6:5] = 00/01/10/11) gives `wrAddr` = 8 + bits [9:7] and `rdAddr` = 8 + bits [4:2].
- R11: When bits [15:13] = 011 and [1:0] = 01, the word is the stack-pointer adjust (`opFlags[6]`) if bits [11:7] = 2, and otherwise load-upper (`opFlags[7]`). In both cases `wrAddr` is bits [11:7].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| instWord | input | 16 | Instruction half-word to decode |
| stallIn | input | 1 | Stage is stalled; blocks the write qualifier |
| bubbleIn | input | 1 | Stage holds a bubble; blocks the write qualifier |
| opFlags | output | 26 | One-hot compressed operation flags, order per R9 |
| isWide | output | 1 | Word begins a 32-bit instruction |
| wrAddr | output | 5 | Write / primary register port address |
| rdAddr | output | 5 | Read-only secondary register port address |
| wrEn | output | 1 | Register write qualifier |

## Verification
The decoder is first driven with hand-picked words. These include the add at 0x9196 next to its look-alikes: the breakpoint 0x9002 and a register jump-and-link with a non-zero rs1. That pairing separates the add flag from the encodings that share its pattern. The load-upper / stack-adjust pair, the three-bit register forms and the reserved words check the field qualifiers and the prime-register offset. After that, thousands of random half-words with random stall and bubble are compared every clock against a behavioural model. The random words cover all three compressed quadrants and the 32-bit marker, so the stall, bubble and x0 gating of the write qualifier is exercised against every writing operation.

// File: rtl/rvc_dec_pkg.sv
package rvc_dec_pkg;
  localparam int INST_W   = 16;
  localparam int REG_W    = 5;
  localparam int CREG_W   = 3;
  localparam int NUM_OPS  = 26;

  localparam logic [REG_W-1:0] RA_REG = 5'd1;
  localparam logic [REG_W-1:0] SP_REG = 5'd2;

  localparam int OP_ADDI4SPN = 0;
  localparam int OP_LW       = 1;
  localparam int OP_SW       = 2;
  localparam int OP_ADDI     = 3;
  localparam int OP_JAL      = 4;
  localparam int OP_LI       = 5;
  localparam int OP_ADDI16SP = 6;
  localparam int OP_LUI      = 7;
  localparam int OP_SRLI     = 8;
  localparam int OP_SRAI     = 9;
  localparam int OP_ANDI     = 10;
  localparam int OP_SUB      = 11;
  localparam int OP_XOR      = 12;
  localparam int OP_OR       = 13;
  localparam int OP_AND      = 14;
  localparam int OP_J        = 15;
  localparam int OP_BEQZ     = 16;
  localparam int OP_BNEZ     = 17;
  localparam int OP_SLLI     = 18;
  localparam int OP_LWSP     = 19;
  localparam int OP_SWSP     = 20;
  localparam int OP_JR       = 21;
  localparam int OP_MV       = 22;
  localparam int OP_EBREAK   = 23;
  localparam int OP_JALR     = 24;
  localparam int OP_ADD      = 25;

  // Port-select strobes handed from control to datapath
  typedef struct packed {
    logic wrRa;       // write port = ra
    logic wrFull;     // write port = bits [11:7]
    logic wrPrimeHi;  // write port = 8 + bits [9:7]
    logic wrPrimeLo;  // write port = 8 + bits [4:2]
    logic rdSp;       // read port = sp
    logic rdFull;     // read port = bits [6:2]
    logic rdPrimeLo;  // read port = 8 + bits [4:2]
  } portStrobe_t;

  function automatic logic [INST_W-1:0] opMask(input int idx);
    case (idx)
      OP_SRLI, OP_SRAI, OP_ANDI:         opMask = 16'hEC03;
      OP_SUB, OP_XOR, OP_OR, OP_AND:     opMask = 16'hFC63;
      OP_JR, OP_JALR:                    opMask = 16'hF07F;
      OP_MV, OP_ADD:                     opMask = 16'hF003;
      OP_EBREAK:                         opMask = 16'hFFFF;
      default:                           opMask = 16'hE003;
    endcase
  endfunction

  function automatic logic [INST_W-1:0] opPattern(input int idx);
    case (idx)
      OP_ADDI4SPN: opPattern = 16'h0000;
      OP_LW:       opPattern = 16'h4000;
      OP_SW:       opPattern = 16'hC000;
      OP_ADDI:     opPattern = 16'h0001;
      OP_JAL:      opPattern = 16'h2001;
      OP_LI:       opPattern = 16'h4001;
      OP_ADDI16SP: opPattern = 16'h6001;
      OP_LUI:      opPattern = 16'h6001;
      OP_SRLI:     opPattern = 16'h8001;
      OP_SRAI:     opPattern = 16'h8401;
      OP_ANDI:     opPattern = 16'h8801;
      OP_SUB:      opPattern = 16'h8C01;
      OP_XOR:      opPattern = 16'h8C21;
      OP_OR:       opPattern = 16'h8C41;
      OP_AND:      opPattern = 16'h8C61;
      OP_J:        opPattern = 16'hA001;
      OP_BEQZ:     opPattern = 16'hC001;
      OP_BNEZ:     opPattern = 16'hE001;
      OP_SLLI:     opPattern = 16'h0002;
      OP_LWSP:     opPattern = 16'h4002;
      OP_SWSP:     opPattern = 16'hC002;
      OP_JR:       opPattern = 16'h8002;
      OP_MV:       opPattern = 16'h8002;
      default:     opPattern = 16'h9002;
    endcase
  endfunction
endpackage

// File: rtl/rvc_dec_ctrl.sv
module rvc_dec_ctrl
  import rvc_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [INST_W-1:0] instWord,
  output portStrobe_t       strobe,
  output logic              wideHit,
  output logic [NUM_OPS-1:0] opFlags,
  output logic              isWide
);
  logic [NUM_OPS-1:0] rawHit;
  logic [NUM_OPS-1:0] qualOk;
  logic [NUM_OPS-1:0] preHit;
  logic [NUM_OPS-1:0] opHit;
  logic               rdNonZero;
  logic               rs2NonZero;

  // mask-and-compare per operation
  for (genvar i = 0; i < NUM_OPS; i++) begin : gMatch
    assign rawHit[i] = ((instWord & opMask(i)) == opPattern(i));
  end

  assign rdNonZero  = |instWord[11:7];
  assign rs2NonZero = |instWord[6:2];
  assign wideHit    = (instWord[1:0] == 2'b11);

  always_comb begin
    qualOk = '1;
    qualOk[OP_ADDI4SPN] = |instWord[12:5];
    qualOk[OP_ADDI16SP] = (instWord[11:7] == SP_REG);
    qualOk[OP_LUI]      = (instWord[11:7] != SP_REG);
    qualOk[OP_JR]       = rdNonZero;
    qualOk[OP_MV]       = rs2NonZero;
    qualOk[OP_JALR]     = rdNonZero;
  end

  assign preHit = rawHit & qualOk;

  // add shares its pattern with the register jump-and-link and breakpoint
  always_comb begin
    opHit = preHit;
    opHit[OP_ADD] = preHit[OP_ADD] & ~preHit[OP_JALR] & ~preHit[OP_EBREAK];
  end

  always_comb begin
    strobe.wrRa      = opHit[OP_JAL] | opHit[OP_JALR] | wideHit;
    strobe.wrFull    = opHit[OP_ADDI] | opHit[OP_LI] | opHit[OP_LUI] |
                       opHit[OP_ADDI16SP] | opHit[OP_SLLI] | opHit[OP_LWSP] |
                       opHit[OP_MV] | opHit[OP_ADD];
    strobe.wrPrimeHi = opHit[OP_SRLI] | opHit[OP_SRAI] | opHit[OP_ANDI] |
                       opHit[OP_SUB] | opHit[OP_XOR] | opHit[OP_OR] | opHit[OP_AND];
    strobe.wrPrimeLo = opHit[OP_LW] | opHit[OP_ADDI4SPN];
    strobe.rdSp      = opHit[OP_ADDI4SPN] | opHit[OP_LWSP] | opHit[OP_SWSP];
    strobe.rdFull    = opHit[OP_ADD] | opHit[OP_MV];
    strobe.rdPrimeLo = opHit[OP_SW] | opHit[OP_SUB] | opHit[OP_XOR] |
                       opHit[OP_OR] | opHit[OP_AND];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opFlags <= '0;
      isWide  <= 1'b0;
    end else begin
      opFlags <= opHit;
      isWide  <= wideHit;
    end
  end

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
    $onehot0({opFlags, isWide})) else $error("flags not one-hot"); // R8

  AST_ADD_NOT_JALR: assert property (@(posedge clk) disable iff (rst)
    (wideHit == 1'b0 && instWord == 16'h9002) |=> opFlags[OP_EBREAK] && !opFlags[OP_ADD])
    else $error("breakpoint word mis-decoded"); // R5
endmodule

// File: rtl/rvc_dec_dpath.sv
module rvc_dec_dpath
  import rvc_dec_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [11:2]      fieldIn,
  input  portStrobe_t      strobe,
  input  logic             stallIn,
  input  logic             bubbleIn,
  output logic [REG_W-1:0] wrAddr,
  output logic [REG_W-1:0] rdAddr,
  output logic             wrEn
);
  localparam int N_WR_SRC = 4;
  localparam int N_RD_SRC = 3;
  localparam logic [REG_W-CREG_W-1:0] PRIME_TOP = 2'b01;

  logic [REG_W-1:0] wrCand  [N_WR_SRC];
  logic [REG_W-1:0] rdCand  [N_RD_SRC];
  logic             wrSel   [N_WR_SRC];
  logic             rdSel   [N_RD_SRC];
  logic [REG_W-1:0] wrGated [N_WR_SRC];
  logic [REG_W-1:0] rdGated [N_RD_SRC];
  logic [REG_W-1:0] wrNext, rdNext;
  logic             anyWrite;

  assign wrCand[0] = RA_REG;
  assign wrCand[1] = fieldIn[11:7];
  assign wrCand[2] = {PRIME_TOP, fieldIn[9:7]};
  assign wrCand[3] = {PRIME_TOP, fieldIn[4:2]};
  assign wrSel[0]  = strobe.wrRa;
  assign wrSel[1]  = strobe.wrFull;
  assign wrSel[2]  = strobe.wrPrimeHi;
  assign wrSel[3]  = strobe.wrPrimeLo;

  assign rdCand[0] = SP_REG;
  assign rdCand[1] = fieldIn[6:2];
  assign rdCand[2] = {PRIME_TOP, fieldIn[4:2]};
  assign rdSel[0]  = strobe.rdSp;
  assign rdSel[1]  = strobe.rdFull;
  assign rdSel[2]  = strobe.rdPrimeLo;

  // AND each candidate with its replicated strobe
  for (genvar k = 0; k < N_WR_SRC; k++) begin : gWrGate
    assign wrGated[k] = wrCand[k] & {REG_W{wrSel[k]}};
  end
  for (genvar k = 0; k < N_RD_SRC; k++) begin : gRdGate
    assign rdGated[k] = rdCand[k] & {REG_W{rdSel[k]}};
  end

  always_comb begin
    wrNext   = '0;
    anyWrite = 1'b0;
    for (int k = 0; k < N_WR_SRC; k++) begin
      wrNext   = wrNext | wrGated[k];
      anyWrite = anyWrite | wrSel[k];
    end
    rdNext = '0;
    for (int k = 0; k < N_RD_SRC; k++) begin
      rdNext = rdNext | rdGated[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrAddr <= '0;
      rdAddr <= '0;
      wrEn   <= 1'b0;
    end else begin
      wrAddr <= wrNext;
      rdAddr <= rdNext;
      wrEn   <= anyWrite & (|wrNext) & ~stallIn & ~bubbleIn;
    end
  end

  AST_WE_NOT_X0: assert property (@(posedge clk) disable iff (rst)
    wrEn |-> (wrAddr != '0)) else $error("write to x0"); // R7

  AST_HOLD_NO_WE: assert property (@(posedge clk) disable iff (rst)
    (stallIn || bubbleIn) |=> !wrEn) else $error("write while held"); // R7

  AST_SP_PORT: assert property (@(posedge clk) disable iff (rst)
    strobe.rdSp |=> (rdAddr == SP_REG)) else $error("sp read port"); // R6

  AST_RA_PORT: assert property (@(posedge clk) disable iff (rst)
    strobe.wrRa |=> (wrAddr == RA_REG)) else $error("ra write port"); // R2
endmodule

// File: rtl/rvc_decoder.sv
module rvc_decoder
  import rvc_dec_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [INST_W-1:0]  instWord,
  input  logic               stallIn,
  input  logic               bubbleIn,
  output logic [NUM_OPS-1:0] opFlags,
  output logic               isWide,
  output logic [REG_W-1:0]   wrAddr,
  output logic [REG_W-1:0]   rdAddr,
  output logic               wrEn
);
  portStrobe_t strobe;
  logic        wideHit;

  rvc_dec_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .instWord (instWord),
    .strobe   (strobe),
    .wideHit  (wideHit),
    .opFlags  (opFlags),
    .isWide   (isWide)
  );

  rvc_dec_dpath u_dpath (
    .clk      (clk),
    .rst      (rst),
    .fieldIn  (instWord[11:2]),
    .strobe   (strobe),
    .stallIn  (stallIn),
    .bubbleIn (bubbleIn),
    .wrAddr   (wrAddr),
    .rdAddr   (rdAddr),
    .wrEn     (wrEn)
  );

  AST_WIDE_NO_OP: assert property (@(posedge clk) disable iff (rst)
    wideHit |=> (isWide && opFlags == '0)) else $error("wide word raised op"); // R2
endmodule

// File: tb/rvc_decoder_bench.sv
module rvc_decoder_bench;
  localparam int NF = 26;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [15:0]   instWord = 16'h0;
  logic          stallIn = 1'b0;
  logic          bubbleIn = 1'b0;
  logic [NF-1:0] opFlags;
  logic          isWide;
  logic [4:0]    wrAddr, rdAddr;
  logic          wrEn;

  int nChecks = 0;
  int nFails  = 0;
  bit pend    = 0;
  logic [NF-1:0] eFlags;
  logic          eWide, eWe;
  logic [4:0]    eWa, eRa;

  always #5 clk = ~clk;

  rvc_decoder u_rvc_decoder (
    .clk(clk), .rst(rst), .instWord(instWord), .stallIn(stallIn),
    .bubbleIn(bubbleIn), .opFlags(opFlags), .isWide(isWide),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrEn(wrEn)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h word=%h", tag, act, exp, instWord);
    end
  endtask

  // behavioural reference, written from the requirements
  task automatic refModel(input logic [15:0] w, input logic st, input logic bu,
                          output logic [NF-1:0] f, output logic wd,
                          output logic [4:0] wa, output logic [4:0] ra,
                          output logic we);
    logic [4:0] rdF, rs2F, pHi, pLo;
    int bitNo;
    rdF = w[11:7]; rs2F = w[6:2];
    pHi = 5'd8 + {2'b00, w[9:7]};
    pLo = 5'd8 + {2'b00, w[4:2]};
    f = '0; wd = 0; wa = 0; ra = 0; bitNo = -1;
    if (w[1:0] == 2'b11) begin
      wd = 1; wa = 1;
    end else if (w[1:0] == 2'b00) begin
      case (w[15:13])
        3'b000: if (w[12:5] != 0) begin bitNo = 0; wa = pLo; ra = 2; end
        3'b010: begin bitNo = 1; wa = pLo; end
        3'b110: begin bitNo = 2; ra = pLo; end
        default: ;
      endcase
    end else if (w[1:0] == 2'b01) begin
      case (w[15:13])
        3'b000: begin bitNo = 3; wa = rdF; end
        3'b001: begin bitNo = 4; wa = 1; end
        3'b010: begin bitNo = 5; wa = rdF; end
        3'b011: begin bitNo = (rdF == 2) ? 6 : 7; wa = rdF; end
        3'b100: begin
          if (w[11:10] != 2'b11) begin bitNo = 8 + w[11:10]; wa = pHi; end
          else if (!w[12]) begin bitNo = 11 + w[6:5]; wa = pHi; ra = pLo; end
        end
        3'b101: bitNo = 15;
        3'b110: bitNo = 16;
        default: bitNo = 17;
      endcase
    end else begin
      case (w[15:13])
        3'b000: begin bitNo = 18; wa = rdF; end
        3'b010: begin bitNo = 19; wa = rdF; ra = 2; end
        3'b110: begin bitNo = 20; ra = 2; end
        3'b100: begin
          if (!w[12]) begin
            if (rs2F != 0) begin bitNo = 22; wa = rdF; ra = rs2F; end
            else if (rdF != 0) bitNo = 21;
          end else begin
            if (rs2F != 0) begin bitNo = 25; wa = rdF; ra = rs2F; end
            else if (rdF != 0) begin bitNo = 24; wa = 1; end
            else bitNo = 23;
          end
        end
        default: ;
      endcase
    end
    if (bitNo >= 0) f[bitNo] = 1'b1;
    we = (wa != 0) && !st && !bu;
  endtask

  task automatic drive(input logic [15:0] w, input logic st, input logic bu);
    instWord = w; stallIn = st; bubbleIn = bu;
    refModel(w, st, bu, eFlags, eWide, eWa, eRa, eWe);
    pend = 1;
  endtask

  task automatic tick();
    @(negedge clk);
    if (pend) begin
      chk("R8 flags vs model", 32'(opFlags), 32'(eFlags));
      chk("R2 wide vs model", 32'(isWide), 32'(eWide));
      chk("R4 wrAddr vs model", 32'(wrAddr), 32'(eWa));
      chk("R6 rdAddr vs model", 32'(rdAddr), 32'(eRa));
      chk("R7 wrEn vs model", 32'(wrEn), 32'(eWe));
    end
  endtask

  task automatic lit(input string tag, input int bitNo, input logic wd,
                     input logic [4:0] wa, input logic [4:0] ra, input logic we);
    logic [NF-1:0] f;
    f = (bitNo >= 0) ? (NF'(1) << bitNo) : '0;
    chk({tag, " flags"}, 32'(opFlags), 32'(f));
    chk({tag, " wide"}, 32'(isWide), 32'(wd));
    chk({tag, " wrAddr"}, 32'(wrAddr), 32'(wa));
    chk({tag, " rdAddr"}, 32'(rdAddr), 32'(ra));
    chk({tag, " wrEn"}, 32'(wrEn), 32'(we));
  endtask

  task automatic one(input logic [15:0] w, input logic st, input logic bu,
                     input string tag, input int bitNo, input logic wd,
                     input logic [4:0] wa, input logic [4:0] ra, input logic we);
    drive(w, st, bu);
    tick();
    lit(tag, bitNo, wd, wa, ra, we);
  endtask

  initial begin
    #(100000 * 10);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    instWord = 16'h9196;
    repeat (3) @(negedge clk);
    lit("R1 reset", -1, 0, 0, 0, 0);
    rst = 1'b0;
    one(16'h9196, 0, 0, "R4 add x3,x5", 25, 0, 3, 5, 1);
    one(16'h9002, 0, 0, "R5 breakpoint", 23, 0, 0, 0, 0);
    one(16'h9082, 0, 0, "R5 jalr ra", 24, 0, 1, 0, 1);
    one(16'h2001, 0, 0, "R5 jal", 4, 0, 1, 0, 1);
    one(16'h4398, 0, 0, "R3 load", 1, 0, 14, 0, 1);
    one(16'h8C89, 0, 0, "R10 sub", 11, 0, 9, 10, 1);
    one(16'h6105, 0, 0, "R11 sp adjust", 6, 0, 2, 0, 1);
    one(16'h6285, 0, 0, "R11 load-upper", 7, 0, 5, 0, 1);
    one(16'h4412, 0, 0, "R6 stack load", 19, 0, 8, 2, 1);
    one(16'h0013, 0, 0, "R2 wide", -1, 1, 1, 0, 1);
    one(16'h0013, 1, 0, "R7 wide stalled", -1, 1, 1, 0, 0);
    one(16'h9196, 0, 1, "R7 add bubble", 25, 0, 3, 5, 0);
    one(16'h9196, 1, 0, "R7 add stalled", 25, 0, 3, 5, 0);
    one(16'h0001, 0, 0, "R7 nop to x0", 3, 0, 0, 0, 0);
    one(16'h0000, 0, 0, "R8 zero word", -1, 0, 0, 0, 0);
    one(16'h9C01, 0, 0, "R8 reserved", -1, 0, 0, 0, 0);
    one(16'h0000, 0, 0, "R9 zero again", -1, 0, 0, 0, 0);
    for (int n = 0; n < 5000; n++) begin
      drive(16'($urandom), ($urandom % 4) == 0, ($urandom % 5) == 0);
      tick();
    end
    rst = 1'b1;
    @(negedge clk);
    pend = 0;
    lit("R1 reset again", -1, 0, 0, 0, 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule